// File: doc/BRIEF.md
# NAND Controller Event Status and Interrupt Register

This block keeps the event status word of a NAND flash controller and produces the controller's single interrupt line. Eleven event inputs come from the command and data engines. Examples are a request for command words, read and write data requests, correctable and uncorrectable ECC errors, and per-chip-select bad-block, command-done and page-done events. Each input is a one-cycle pulse that sets a sticky status bit. Software clears a bit by writing a one to it. Writing back a value just read therefore clears exactly the events that software has seen.

The top bit of the status word is not sticky. It shows the flash ready/busy pin after a two-stage synchronizer.

The interrupt enable is the low twelve bits of the control register, and it works in inverted sense: a one suppresses that event's interrupt. Reset sets every mask bit, so all interrupts start disabled. The interrupt output is a registered level. It is high while any unmasked sticky event bit is set. The ready bit never contributes to it.

Top module: `nfc_evt_regs`

## Requirements
- R1: After reset, the sticky status bits [10:0] read 0, the control register reads 0xFFF (all interrupts masked), and `irq_o` is 0.
- R2: A pulse on `evt_set[i]` (i in 0..10) sets status bit i at the next clock edge. The bit stays set after the pulse ends until software clears it.
- R3: A write with `wr_sel`=0 (status) clears every status bit [10:0] whose data bit is 1. Bits written as 0 keep their value.
- R4: When a set pulse and a write-one-to-clear hit the same bit in the same cycle, the bit remains set.
- R5: `rd_data` is registered and shows one cycle later the register picked by `rd_sel` (0 = status, 1 = control). Only bits [11:0] are returned; bits above 11 read 0.
- R6: Status bit 11 equals `rdy_pin` delayed by two clock stages. Reading it captures the value one cycle later still. Writes to status bit 11 and to status bits above 11 have no effect.
- R7: `irq_o` is a registered level equal to the OR over bits [10:0] of (status AND NOT mask). It changes one clock after the status or mask change. The ready bit and mask bit 11 never affect it.
- R8: A write with `wr_sel`=1 (control) loads data bits [11:0] into the mask, where a 1 disables the matching interrupt. Data bits above 11 are dropped.
- R9: Reading the status word and writing the same value back clears only those bits. An event that arrives between the read and the write-back stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | EVT_W-1 | One-cycle event pulses for status bits [10:0] |
| rdy_pin | input | 1 | Asynchronous flash ready/busy pin, high = ready |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (write-one-to-clear), 1 control mask |
| wr_data | input | DW | Write data |
| rd_sel | input | 1 | Read target: 0 status, 1 control |
| rd_data | output | DW | Registered read data |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The hardest condition to reach from the ports is the same-cycle collision between an event pulse and a write-one-to-clear on the same bit. The bench drives both on one falling edge for each of the eleven event bits. It then reads back to confirm that only the colliding bit survived.

The read-versus-write-back race is reached by injecting a new event between a status read and its write-back. The mask is swept over all 4096 values against two fixed status patterns, so every mask bit, including the ignored bit 11, is tested against the interrupt level.

// File: rtl/nfc_evt_pkg.sv
package nfc_evt_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CTRL   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/nfc_rdy_sync.sv
module nfc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nfc_sticky_bank.sv
module nfc_sticky_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  genvar b;
  generate
    for (b = 0; b < N; b++) begin : g_bit
      // set has priority over a simultaneous clear
      always_ff @(posedge clk) begin
        if (rst)           q_o[b] <= 1'b0;
        else if (set_i[b]) q_o[b] <= 1'b1;
        else if (clr_i[b]) q_o[b] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/nfc_irq_gen.sv
module nfc_irq_gen #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic pending;
  assign pending = |(status_i & ~mask_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pending;
  end
endmodule

// File: rtl/nfc_evt_regs.sv
module nfc_evt_regs
  import nfc_evt_pkg::*;
#(
  parameter int EVT_W = 12,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-2:0] evt_set,
  input  logic             rdy_pin,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             irq_o
);
  localparam int NEV = EVT_W - 1;

  logic [NEV-1:0]   sticky_q;
  logic [NEV-1:0]   clr_vec;
  logic [EVT_W-1:0] mask_q;
  logic             rdy_s;
  logic [EVT_W-1:0] status_word;
  logic             wr_status;
  logic             wr_ctrl;

  assign wr_status = wr_en && (reg_sel_e'(wr_sel) == SEL_STATUS);
  assign wr_ctrl   = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign clr_vec   = wr_status ? wr_data[NEV-1:0] : '0;

  nfc_rdy_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (rdy_pin),
    .sync_o (rdy_s)
  );

  nfc_sticky_bank #(.N(NEV)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .set_i (evt_set),
    .clr_i (clr_vec),
    .q_o   (sticky_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (wr_ctrl) mask_q <= wr_data[EVT_W-1:0];
  end

  nfc_irq_gen #(.N(NEV)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .status_i (sticky_q),
    .mask_i   (mask_q[NEV-1:0]),
    .irq_o    (irq_o)
  );

  assign status_word = {rdy_s, sticky_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (reg_sel_e'(rd_sel) == SEL_CTRL) rd_data[EVT_W-1:0] <= mask_q;
      else                                rd_data[EVT_W-1:0] <= status_word;
    end
  end
endmodule

// File: rtl/nfc_evt_regs_chk.sv
module nfc_evt_regs_chk
  import nfc_evt_pkg::*;
#(
  parameter int EVT_W = 12,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [EVT_W-2:0] evt_set,
  input logic             rdy_pin,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [DW-1:0]    wr_data,
  input logic [EVT_W-2:0] sticky,
  input logic [EVT_W-1:0] mask,
  input logic             rdy_s,
  input logic             irq_o
);
  localparam int NEV = EVT_W - 1;

  logic wr_st;
  assign wr_st = wr_en && (reg_sel_e'(wr_sel) == SEL_STATUS);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sticky == '0 && mask == '1 && !irq_o));

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((sticky & $past(evt_set)) == $past(evt_set)));

  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_st |=> ((sticky & $past(sticky)) == $past(sticky)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    wr_st |=> ((sticky & $past(wr_data[NEV-1:0] & ~evt_set)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_st && |(evt_set & wr_data[NEV-1:0])) |=>
      ((sticky & $past(evt_set)) == $past(evt_set)));

  assert_ready_sync_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (rdy_s == $past(rdy_pin, 2)));

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(sticky & ~mask[NEV-1:0]))));
endmodule

bind nfc_evt_regs nfc_evt_regs_chk #(.EVT_W(EVT_W), .DW(DW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .evt_set (evt_set),
  .rdy_pin (rdy_pin),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .sticky  (sticky_q),
  .mask    (mask_q),
  .rdy_s   (rdy_s),
  .irq_o   (irq_o)
);

// File: tb/nfc_evt_regs_tb_top.sv
`timescale 1ns/1ps
module nfc_evt_regs_tb_top;
  localparam int EVT_W = 12;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [10:0]   evt_set = '0;
  logic          rdy_pin = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_sel = 1'b0;
  logic [DW-1:0] rd_data;
  logic          irq_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [10:0] exp_st   = '0;
  logic [11:0] exp_mask = 12'hFFF;
  logic        exp_rdy  = 1'b0;

  always #2 clk = ~clk;

  nfc_evt_regs #(.EVT_W(EVT_W), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .evt_set(evt_set), .rdy_pin(rdy_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |(exp_st & ~exp_mask[10:0]);
  endfunction

  task automatic pulse(input logic [10:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = '0;
    exp_st |= v;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (sel) exp_mask = d[11:0];
    else     exp_st   = exp_st & ~d[10:0];
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    @(negedge clk); rd_sel = sel;
    @(negedge clk); v = rd_data;
  endtask

  function automatic logic [31:0] st_word();
    return {20'h0, exp_rdy, exp_st};
  endfunction

  initial begin
    logic [31:0] v;
    logic [31:0] seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(1'b0, v); check(v, 32'h0, "R1 status after reset");
    rd(1'b1, v); check(v, 32'h0000_0FFF, "R1 control after reset");
    check({31'h0, irq_o}, 32'h0, "R1 irq after reset");

    // R2 every event bit sets and sticks
    for (int i = 0; i < 11; i++) begin
      pulse(11'(1 << i));
      repeat (2) @(negedge clk);
      rd(1'b0, v); check(v, st_word(), $sformatf("R2 sticky bit %0d", i));
    end
    check({31'h0, irq_o}, 32'h0, "R7 all masked no irq");

    // R3 write-one-to-clear
    wr(1'b0, 32'h0); rd(1'b0, v); check(v, st_word(), "R3 zero write keeps");
    wr(1'b0, 32'h555); rd(1'b0, v); check(v, 32'h2AA, "R3 partial clear");
    // R6 writes to bit 11 and above ignored
    wr(1'b0, 32'hFFFF_F800); rd(1'b0, v); check(v, 32'h2AA, "R6 upper write ignored");
    wr(1'b0, 32'h2AA); rd(1'b0, v); check(v, 32'h0, "R3 full clear");

    // R4 set wins over clear in same cycle, per bit
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      evt_set = 11'(1 << i); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h7FF;
      @(negedge clk);
      evt_set = '0; wr_en = 1'b0;
      exp_st = 11'(1 << i);
      rd(1'b0, v); check(v, st_word(), $sformatf("R4 collision bit %0d", i));
      wr(1'b0, 32'h7FF);
      rd(1'b0, v); check(v, 32'h0, $sformatf("R3 clear after collision %0d", i));
    end

    // R9 read-modify-write keeps a late event
    pulse(11'h003);
    rd(1'b0, seen);
    pulse(11'h100);
    wr(1'b0, seen);
    rd(1'b0, v); check(v, 32'h100, "R9 late event survives write-back");
    wr(1'b0, 32'h7FF);

    // R7 irq timing: one cycle after status change
    wr(1'b1, 32'h0);
    @(negedge clk); check({31'h0, irq_o}, 32'h0, "R7 unmasked idle no irq");
    pulse(11'h040);
    check({31'h0, irq_o}, 32'h0, "R7 irq not before register stage");
    @(negedge clk); check({31'h0, irq_o}, 32'h1, "R7 irq rises");
    wr(1'b0, 32'h040);
    check({31'h0, irq_o}, 32'h1, "R7 irq held one cycle after clear");
    @(negedge clk); check({31'h0, irq_o}, 32'h0, "R7 irq falls");

    // R7/R8 full mask sweep against two patterns
    for (int p = 0; p < 2; p++) begin
      wr(1'b0, 32'h7FF);
      pulse(p == 0 ? 11'h7FF : 11'h020);
      for (int m = 0; m < 4096; m++) begin
        wr(1'b1, 32'hABC0_0000 | 32'(m));
        @(negedge clk);
        check({31'h0, irq_o}, {31'h0, exp_irq()}, $sformatf("R7 mask %03h pattern %0d", m, p));
        if ((m % 256) == 7) begin
          rd(1'b1, v); check(v, 32'(m), $sformatf("R8 mask readback %03h", m));
        end
      end
    end
    wr(1'b0, 32'h7FF);
    wr(1'b1, 32'h0);

    // R6 ready pin through two stages, read one cycle later
    @(negedge clk); rd_sel = 1'b0; rdy_pin = 1'b1;
    @(negedge clk); check(rd_data, 32'h0, "R6 ready stage 1 old");
    @(negedge clk); check(rd_data, 32'h0, "R6 ready stage 2 old");
    @(negedge clk); check(rd_data, 32'h800, "R6 ready visible");
    exp_rdy = 1'b1;
    check({31'h0, irq_o}, 32'h0, "R7 ready never raises irq");
    wr(1'b0, 32'h800); rd(1'b0, v); check(v, 32'h800, "R6 ready not cleared by write");
    @(negedge clk); rdy_pin = 1'b0;
    @(negedge clk); check(rd_data, 32'h800, "R6 fall stage 1 old");
    @(negedge clk); check(rd_data, 32'h800, "R6 fall stage 2 old");
    @(negedge clk); check(rd_data, 32'h0, "R6 ready low visible");
    exp_rdy = 1'b0;

    // R5 control read hides upper bits
    wr(1'b1, 32'hFFFF_F123); rd(1'b1, v); check(v, 32'h123, "R5 control upper bits zero");
    rd(1'b0, v); check(v, 32'h0, "R5 status read after control");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule